// File: doc/BRIEF.md
# Bit-Field and Conditional Integer Unit

A purely combinational 32-bit integer execution unit that serves a handful of instruction-set extensions inside a processor datapath. An opcode select picks one of six operations: pulling a field out of a word, depositing a field into an existing word, a move gated by whether a condition operand is zero, and counting the run of ones or zeros at the top of a word.

The unit sees two source operands, the current destination register value, a 5-bit bit position and a field size encoded 1 to 32. It returns the value to write and a write-enable, and it raises an error flag when a field operation asks for a field that does not fit in the word. The register file uses the write-enable to decide whether to update the destination. Decoding, the register file itself, multiply-accumulate and hazard handling live elsewhere.

Top module: `bit_field_cond_unit`

## Requirements
- R1: With op_i = 0 (extract), res_o holds size_i bits of src_a_i taken from bit pos_i upward, right-justified, with every bit at or above size_i cleared; for example src_a_i = 0x11223344, pos_i = 8, size_i = 8 gives 0x00000033.
- R2: With op_i = 1 (insert), res_o equals dst_old_i with bits pos_i to pos_i+size_i-1 replaced by the lowest size_i bits of src_a_i; bits of src_a_i above size_i have no effect; for example 0xAA at pos_i = 16, size_i = 8 into 0x11223344 gives 0x11AA3344.
- R3: With op_i = 2 (move if non-zero), when src_b_i is not zero res_o equals src_a_i and wr_en_o is 1; when src_b_i is zero wr_en_o is 0.
- R4: With op_i = 3 (move if zero), when src_b_i is zero res_o equals src_a_i and wr_en_o is 1; otherwise wr_en_o is 0.
- R5: With op_i = 4, res_o is the count of consecutive one bits of src_a_i starting from bit 31, zero-extended; an all-ones input gives 32.
- R6: With op_i = 5, res_o is the count of consecutive zero bits of src_a_i starting from bit 31, zero-extended; an all-zeros input gives 32.
- R7: For extract and insert, size_i is the field width directly (1 to 32); size_i = 0, size_i above 32 or pos_i + size_i above 32 is illegal and gives err_o = 1, wr_en_o = 0 and res_o = dst_old_i.
- R8: Opcodes 6 and 7 are unused and give err_o = 1, wr_en_o = 0 and res_o = dst_old_i; opcodes 2 to 5 never raise err_o, whatever pos_i and size_i hold.
- R9: Legal extract and insert, and both count operations, drive wr_en_o = 1 and err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation select (0 extract, 1 insert, 2 move if non-zero, 3 move if zero, 4 count leading ones, 5 count leading zeros) |
| src_a_i | input | 32 | Primary source operand |
| src_b_i | input | 32 | Condition operand for the moves |
| dst_old_i | input | 32 | Current destination register value |
| pos_i | input | 5 | Lowest bit of the field |
| size_i | input | 6 | Field width, 1 to 32 |
| res_o | output | 32 | Result value |
| wr_en_o | output | 1 | Destination write-enable |
| err_o | output | 1 | Illegal field or unused opcode |

## Verification
The field legality check runs in the same cycle as every other operation, so an illegal position and size can coincide with a conditional move or a count. The bench provokes this by issuing moves and counts with pos_i + size_i beyond the word and with size_i = 0, and judges that err_o stays low while the move or count result and write-enable come out exactly as without the stray field. It also pairs field operations at the legal limits (pos 31 size 1, pos 0 size 32) with their first illegal neighbours to catch off-by-one checks.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_EXT  = 3'd0,
    OP_INS  = 3'd1,
    OP_MOVN = 3'd2,
    OP_MOVZ = 3'd3,
    OP_CLO  = 3'd4,
    OP_CLZ  = 3'd5
  } bfc_op_e;
endpackage

// File: rtl/bfc_mask_gen.sv
module bfc_mask_gen #(
  parameter int DATA_W = 32,
  localparam int SIZE_W = $clog2(DATA_W + 1)
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W:0] wide;

  // one extra bit so a full-width size yields all ones
  always_comb begin
    wide   = ({{DATA_W{1'b0}}, 1'b1} << size_i) - {{DATA_W{1'b0}}, 1'b1};
    mask_o = wide[DATA_W-1:0];
  end
endmodule

// File: rtl/bfc_field.sv
module bfc_field #(
  parameter int DATA_W = 32,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int SIZE_W = $clog2(DATA_W + 1),
  localparam int SUM_W  = SIZE_W + 1
) (
  input  logic              ins_sel_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] res_o,
  output logic              legal_o
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] place_mask;
  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] ins_val;
  logic [SUM_W-1:0]  end_bit;

  bfc_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .size_i (size_i),
    .mask_o (mask)
  );

  always_comb begin
    end_bit    = SUM_W'(size_i) + SUM_W'(pos_i);
    legal_o    = (size_i != '0) && (end_bit <= SUM_W'(DATA_W));
    place_mask = mask << pos_i;
    ext_val    = (src_i >> pos_i) & mask;
    ins_val    = (dst_i & ~place_mask) | ((src_i & mask) << pos_i);
    res_o      = ins_sel_i ? ins_val : ext_val;
  end
endmodule

// File: rtl/bfc_lead_count.sv
module bfc_lead_count #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              ones_sel_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] scan;

  // counting ones == counting zeros of the complement
  always_comb begin
    scan  = ones_sel_i ? ~src_i : src_i;
    cnt_o = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (scan[i]) cnt_o = CNT_W'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/bfc_cond_move.sv
module bfc_cond_move #(
  parameter int DATA_W = 32
) (
  input  logic              on_zero_i,
  input  logic [DATA_W-1:0] cond_i,
  output logic              take_o
);
  logic is_zero;

  always_comb begin
    is_zero = (cond_i == '0);
    take_o  = on_zero_i ? is_zero : ~is_zero;
  end
endmodule

// File: rtl/bit_field_cond_unit.sv
module bit_field_cond_unit
  import bfc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int SIZE_W = $clog2(DATA_W + 1)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] dst_old_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              err_o
);
  logic [DATA_W-1:0] field_res;
  logic              field_legal;
  logic [SIZE_W-1:0] lead_cnt;
  logic              move_take;

  bfc_field #(.DATA_W(DATA_W)) u_field (
    .ins_sel_i (op_i == OP_INS),
    .src_i     (src_a_i),
    .dst_i     (dst_old_i),
    .pos_i     (pos_i),
    .size_i    (size_i),
    .res_o     (field_res),
    .legal_o   (field_legal)
  );

  bfc_lead_count #(.DATA_W(DATA_W)) u_lead (
    .ones_sel_i (op_i == OP_CLO),
    .src_i      (src_a_i),
    .cnt_o      (lead_cnt)
  );

  bfc_cond_move #(.DATA_W(DATA_W)) u_move (
    .on_zero_i (op_i == OP_MOVZ),
    .cond_i    (src_b_i),
    .take_o    (move_take)
  );

  always_comb begin
    res_o   = dst_old_i;
    wr_en_o = 1'b0;
    err_o   = 1'b0;
    case (op_i)
      OP_EXT, OP_INS: begin
        if (field_legal) begin
          res_o   = field_res;
          wr_en_o = 1'b1;
        end else begin
          err_o = 1'b1;
        end
      end
      OP_MOVN, OP_MOVZ: begin
        if (move_take) begin
          res_o   = src_a_i;
          wr_en_o = 1'b1;
        end
      end
      OP_CLO, OP_CLZ: begin
        res_o   = DATA_W'(lead_cnt);
        wr_en_o = 1'b1;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bit_field_cond_unit_chk.sv
module bit_field_cond_unit_chk
  import bfc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int SIZE_W = $clog2(DATA_W + 1),
  localparam int SUM_W  = SIZE_W + 1
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [DATA_W-1:0] dst_old_i,
  input logic [POS_W-1:0]  pos_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic              err_o
);
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] below;
  logic [SUM_W-1:0]  top;
  logic [POS_W-1:0]  hit_idx;
  logic              fld_op;

  always_comb begin
    diff    = res_o ^ dst_old_i;
    below   = ({{(DATA_W-1){1'b0}}, 1'b1} << pos_i) - {{(DATA_W-1){1'b0}}, 1'b1};
    top     = SUM_W'(pos_i) + SUM_W'(size_i);
    hit_idx = POS_W'(DATA_W - 1) - res_o[POS_W-1:0];
    fld_op  = (op_i == OP_EXT) || (op_i == OP_INS);

    if (err_o) begin
      p_err_holds_dst_r7: assert (res_o == dst_old_i && !wr_en_o);
    end
    if (!fld_op && op_i <= OP_CLZ) begin
      p_no_err_other_r8: assert (!err_o);
    end
    if (op_i == OP_EXT && !err_o && size_i < SIZE_W'(DATA_W)) begin
      p_ext_upper_clear_r1: assert ((res_o >> size_i) == '0);
    end
    if (op_i == OP_INS && !err_o) begin
      p_ins_low_keep_r2: assert ((diff & below) == '0);
      if (top < SUM_W'(DATA_W)) begin
        p_ins_high_keep_r2: assert ((diff >> top) == '0);
      end
    end
    if (op_i == OP_MOVN) begin
      p_movn_we_r3: assert (wr_en_o == (src_b_i != '0));
    end
    if (op_i == OP_MOVZ) begin
      p_movz_we_r4: assert (wr_en_o == (src_b_i == '0));
    end
    if ((op_i == OP_MOVN || op_i == OP_MOVZ) && wr_en_o) begin
      p_move_data_r3: assert (res_o == src_a_i);
    end
    if (op_i == OP_CLO) begin
      p_clo_range_r5: assert (res_o <= DATA_W'(DATA_W) && wr_en_o);
      if (res_o < DATA_W'(DATA_W)) begin
        p_clo_stop_r5: assert (!src_a_i[hit_idx]);
      end
    end
    if (op_i == OP_CLZ) begin
      p_clz_range_r6: assert (res_o <= DATA_W'(DATA_W) && wr_en_o);
      if (res_o < DATA_W'(DATA_W)) begin
        p_clz_stop_r6: assert (src_a_i[hit_idx]);
      end
    end
    if (fld_op && !err_o) begin
      p_field_we_r9: assert (wr_en_o);
    end
  end
endmodule

bind bit_field_cond_unit bit_field_cond_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i      (op_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .dst_old_i (dst_old_i),
  .pos_i     (pos_i),
  .size_i    (size_i),
  .res_o     (res_o),
  .wr_en_o   (wr_en_o),
  .err_o     (err_o)
);

// File: tb/tb_bit_field_cond_unit.sv
module tb_bit_field_cond_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op;
  logic [31:0] a, b, d, res;
  logic [4:0]  pos;
  logic [5:0]  size;
  logic        we, err;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  bit_field_cond_unit dut (
    .op_i (op), .src_a_i (a), .src_b_i (b), .dst_old_i (d),
    .pos_i (pos), .size_i (size),
    .res_o (res), .wr_en_o (we), .err_o (err)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic [31:0] sa, logic [31:0] sb,
                       logic [31:0] sd, logic [4:0] p, logic [5:0] s);
    @(negedge clk);
    op = o; a = sa; b = sb; d = sd; pos = p; size = s;
    #2;
  endtask

  task automatic expect_out(string req, logic [31:0] r, logic w, logic e);
    chk(req, res, r);
    chk(req, {31'd0, we}, {31'd0, w});
    chk(req, {31'd0, err}, {31'd0, e});
  endtask

  task automatic t_reset;
    drive(3'd2, 32'h1234, 32'd0, 32'h55, 5'd0, 6'd0);
    expect_out("R3 idle", 32'h55, 1'b0, 1'b0);
  endtask

  task automatic t_extract;
    drive(3'd0, 32'h11223344, 0, 32'hDEAD, 5'd8, 6'd8);
    expect_out("R1 ext p8 s8", 32'h33, 1'b1, 1'b0);
    drive(3'd0, 32'h11223344, 0, 0, 5'd0, 6'd32);
    expect_out("R1 ext full", 32'h11223344, 1'b1, 1'b0);
    drive(3'd0, 32'hF0000000, 0, 0, 5'd28, 6'd4);
    expect_out("R1 ext top", 32'hF, 1'b1, 1'b0);
    drive(3'd0, 32'h80000000, 0, 0, 5'd31, 6'd1);
    expect_out("R9 ext p31 s1", 32'h1, 1'b1, 1'b0);
  endtask

  task automatic t_insert;
    drive(3'd1, 32'hAA, 0, 32'h11223344, 5'd16, 6'd8);
    expect_out("R2 ins p16 s8", 32'h11AA3344, 1'b1, 1'b0);
    drive(3'd1, 32'hFFFFFFFF, 0, 32'h0, 5'd4, 6'd4);
    expect_out("R2 ins high src ignored", 32'hF0, 1'b1, 1'b0);
    drive(3'd1, 32'h1, 0, 32'h0, 5'd31, 6'd1);
    expect_out("R2 ins p31", 32'h80000000, 1'b1, 1'b0);
    drive(3'd1, 32'hCAFEF00D, 0, 32'h12345678, 5'd0, 6'd32);
    expect_out("R9 ins full", 32'hCAFEF00D, 1'b1, 1'b0);
  endtask

  task automatic t_moves;
    drive(3'd2, 32'hA5A5, 32'd5, 32'h77, 5'd0, 6'd1);
    expect_out("R3 movn taken", 32'hA5A5, 1'b1, 1'b0);
    drive(3'd2, 32'hA5A5, 32'd0, 32'h77, 5'd0, 6'd1);
    chk("R3 movn not taken we", {31'd0, we}, 32'd0);
    drive(3'd3, 32'h5A5A, 32'd0, 32'h77, 5'd0, 6'd1);
    expect_out("R4 movz taken", 32'h5A5A, 1'b1, 1'b0);
    drive(3'd3, 32'h5A5A, 32'h80000000, 32'h77, 5'd0, 6'd1);
    chk("R4 movz not taken we", {31'd0, we}, 32'd0);
  endtask

  task automatic t_counts;
    drive(3'd5, 32'h0, 0, 32'h99, 5'd0, 6'd0);
    expect_out("R6 clz zero", 32'd32, 1'b1, 1'b0);
    drive(3'd5, 32'h00010000, 0, 0, 5'd0, 6'd0);
    chk("R6 clz mid", res, 32'd15);
    drive(3'd5, 32'h80000000, 0, 0, 5'd0, 6'd0);
    chk("R6 clz top", res, 32'd0);
    drive(3'd4, 32'hFFFFFFFF, 0, 0, 5'd0, 6'd0);
    expect_out("R5 clo ones", 32'd32, 1'b1, 1'b0);
    drive(3'd4, 32'hF0000000, 0, 0, 5'd0, 6'd0);
    chk("R5 clo four", res, 32'd4);
    drive(3'd4, 32'h7FFFFFFF, 0, 0, 5'd0, 6'd0);
    chk("R5 clo none", res, 32'd0);
  endtask

  task automatic t_illegal;
    drive(3'd0, 32'h11223344, 0, 32'hBEEF, 5'd4, 6'd0);
    expect_out("R7 size zero", 32'hBEEF, 1'b0, 1'b1);
    drive(3'd1, 32'hFF, 0, 32'h1234, 5'd20, 6'd13);
    expect_out("R7 overrun", 32'h1234, 1'b0, 1'b1);
    drive(3'd0, 32'hFF, 0, 32'h4321, 5'd0, 6'd33);
    expect_out("R7 size 33", 32'h4321, 1'b0, 1'b1);
    drive(3'd0, 32'hFF, 0, 32'h4321, 5'd1, 6'd32);
    expect_out("R7 p1 s32", 32'h4321, 1'b0, 1'b1);
    drive(3'd6, 32'hFF, 32'h1, 32'h600D, 5'd0, 6'd8);
    expect_out("R8 op6", 32'h600D, 1'b0, 1'b1);
    drive(3'd7, 32'hFF, 32'h1, 32'h700D, 5'd0, 6'd8);
    expect_out("R8 op7", 32'h700D, 1'b0, 1'b1);
  endtask

  // field legality coincident with non-field ops
  task automatic t_overlap;
    drive(3'd3, 32'hC0DE, 32'd0, 32'h1, 5'd31, 6'd32);
    expect_out("R8 movz with bad field", 32'hC0DE, 1'b1, 1'b0);
    drive(3'd2, 32'hC0DE, 32'd0, 32'h1, 5'd31, 6'd0);
    expect_out("R8 movn with bad field", 32'h1, 1'b0, 1'b0);
    drive(3'd5, 32'h00000100, 0, 0, 5'd30, 6'd40);
    expect_out("R8 clz with bad field", 32'd23, 1'b1, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    op = 3'd2; a = '0; b = '0; d = '0; pos = '0; size = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_extract();
    t_insert();
    t_moves();
    t_counts();
    t_illegal();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule